// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block sends one packet onto the two data lines of a low-speed USB port, one line state per bit time. A start strobe carries the packet length in bytes, and that length counts the sync byte. The block generates the sync byte itself. It fetches the remaining bytes one at a time through a read port into a small packet buffer held outside the block. Each byte goes out least significant bit first. The block applies NRZI encoding, inserts stuff bits, and closes the packet with an end-of-packet pattern. It then stops driving the lines and pulses `done`.

Before the block drives the lines, it presents the idle (J) state with the drivers still off, and it enables them one clock later. A device-address change can be held pending at `pend_addr`. The block copies it into `active_addr` when a data packet completes. A two-byte handshake packet never copies it. The bit period is a whole number of clocks with no fractional correction, so the clock must be chosen to keep the rate error under 1.5%.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset `line_oe`, `line_dp`, `line_dm` and `done` are 0 and `active_addr` is 0.
- R2: In the clock after an accepted start, the lines show J (`line_dp`=0, `line_dm`=1) with `line_oe`=0. `line_oe` rises in the next clock.
- R3: The bits sent are the sync byte 0x80, then buffer entries 0 to `byte_count`-2 read through `rd_addr`. Every byte goes out LSb first.
- R4: NRZI coding starts from J. A 0 bit toggles both lines and a 1 bit leaves them unchanged. While data is being sent, `line_dm` is always the inverse of `line_dp`.
- R5: After six consecutive 1 bits, one toggle is inserted as a stuff bit. The run of ones carries across byte boundaries, and it is also checked after the last data bit. The run of ones restarts at zero for each packet.
- R6: Every data and stuff bit lasts exactly CLKS_PER_BIT clocks.
- R7: End of packet is both lines low with `line_oe`=1 for 2×CLKS_PER_BIT clocks, then J for CLKS_PER_BIT clocks. After that, `line_oe`=0 and both lines are low.
- R8: `done` is high for exactly one clock, namely the first clock in which the bus is released.
- R9: A start strobe while a packet is in progress has no effect.
- R10: A start with `byte_count` below 2 or above MAX_BYTES has no effect.
- R11: When a packet with `byte_count` > 2 completes, `active_addr` takes `pend_addr` in the same clock that `done` rises. A 2-byte packet leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for a packet |
| byte_count | input | CNT_W | Packet length in bytes, counting the sync byte |
| rd_addr | output | CNT_W | Buffer index of the next payload byte |
| rd_data | input | 8 | Buffer byte at `rd_addr`, valid in the same clock |
| pend_addr | input | ADDR_W | Device address that waits to be committed |
| line_dp | output | 1 | Value driven on the D+ line |
| line_dm | output | 1 | Value driven on the D- line |
| line_oe | output | 1 | Line driver enable |
| active_addr | output | ADDR_W | Device address currently in use |
| done | output | 1 | One-clock pulse when the bus is released |

## Verification
A wrong run-of-ones count or a wrong bit index shows up on the lines within one bit time. It appears as an extra or missing toggle, and every later bit of the packet then shifts by one position. A wrong state or timer count shows as an SE0 or J phase of the wrong length, or as `done` and `line_oe` falling at the wrong clock. The bench therefore compares every clock of every packet against a waveform built from the requirements. A bad commit condition is seen at `active_addr` as soon as `done` pulses.

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int MAX_BYTES    = 12,
  parameter int ADDR_W       = 7,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int TMR_W = $clog2(2 * CLKS_PER_BIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [CNT_W-1:0]  rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe,
  output logic [ADDR_W-1:0] active_addr,
  output logic              done
);

  typedef enum logic [2:0] {S_IDLE, S_PRESET, S_SEND, S_SE0, S_EOPJ} st_t;

  st_t              state;
  logic [TMR_W-1:0] tmr;
  logic [7:0]       shreg;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] bidx;
  logic [CNT_W-1:0] nbytes;
  logic             more;
  logic [2:0]       ones;
  logic             level;

  wire tmr_last = (state == S_SE0) ? (tmr == TMR_W'(2 * CLKS_PER_BIT - 1))
                                   : (tmr == TMR_W'(CLKS_PER_BIT - 1));
  wire launch   = (state == S_PRESET) || (state == S_SEND && tmr_last);
  wire start_ok = (state == S_IDLE) && start &&
                  (byte_count >= CNT_W'(2)) && (byte_count <= CNT_W'(MAX_BYTES));

  assign rd_addr = bidx - CNT_W'(1);
  assign line_oe = (state == S_SEND) || (state == S_SE0) || (state == S_EOPJ);
  assign line_dp = (state == S_SEND) && level;
  assign line_dm = ((state == S_SEND) && !level) || (state == S_PRESET) || (state == S_EOPJ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tmr         <= '0;
      shreg       <= '0;
      bit_idx     <= '0;
      bidx        <= '0;
      nbytes      <= '0;
      more        <= 1'b0;
      ones        <= '0;
      level       <= 1'b0;
      active_addr <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_ok) begin
            state   <= S_PRESET;
            nbytes  <= byte_count;
            shreg   <= 8'h80;
            bit_idx <= '0;
            bidx    <= CNT_W'(1);
            more    <= 1'b1;
            ones    <= '0;
            level   <= 1'b0;
            tmr     <= '0;
          end
        end
        S_PRESET, S_SEND: begin
          if (launch) begin
            tmr <= '0;
            if (ones == 3'd6) begin
              level <= ~level;
              ones  <= '0;
              state <= S_SEND;
            end else if (!more) begin
              state <= S_SE0;
            end else begin
              state <= S_SEND;
              if (shreg[0]) begin
                ones <= ones + 3'd1;
              end else begin
                level <= ~level;
                ones  <= '0;
              end
              shreg   <= shreg >> 1;
              bit_idx <= bit_idx + 3'd1;
              if (bit_idx == 3'd7) begin
                if (bidx == nbytes) begin
                  more <= 1'b0;
                end else begin
                  shreg <= rd_data;
                  bidx  <= bidx + CNT_W'(1);
                end
              end
            end
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        S_SE0: begin
          if (tmr_last) begin
            state <= S_EOPJ;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        S_EOPJ: begin
          if (tmr_last) begin
            state <= S_IDLE;
            tmr   <= '0;
            done  <= 1'b1;
            if (nbytes > CNT_W'(2)) active_addr <= pend_addr;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_dp,
  input logic              line_dm,
  input logic              line_oe,
  input logic              done,
  input logic [ADDR_W-1:0] active_addr
);

  AST_OE_AFTER_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(line_dm && !line_dp)); // R2

  AST_DIFF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_dp) |-> !line_dm); // R4

  AST_RELEASE_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(line_dm && !line_dp)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!line_oe && !line_dp && !line_dm)); // R8

  AST_ADDR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_addr != $past(active_addr)) |-> done); // R11

endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/usb_ls_tx_test.sv
module usb_ls_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPB   = 8;
  localparam int MAXB  = 12;
  localparam int CNT_W = 4;
  localparam int AW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [CNT_W-1:0] rd_addr;
  logic [7:0] rd_data;
  logic [AW-1:0] pend_addr = '0;
  logic line_dp, line_dm, line_oe, done;
  logic [AW-1:0] active_addr;

  logic [7:0] mem [0:15];
  logic exp_lv [0:255];
  int nb;
  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_addr = '0;
  int cyc = 0;

  assign rd_data = mem[rd_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ls_tx #(.CLKS_PER_BIT(CPB), .MAX_BYTES(MAXB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .rd_addr(rd_addr), .rd_data(rd_data), .pend_addr(pend_addr),
    .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe),
    .active_addr(active_addr), .done(done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", tag, got, expv);
    end
  endtask

  task automatic build(input int cnt);
    logic lvl = 1'b0;
    int ones = 0;
    nb = 0;
    for (int b = 0; b < cnt; b++) begin
      logic [7:0] by = (b == 0) ? 8'h80 : mem[b-1];
      for (int k = 0; k < 8; k++) begin
        if (ones == 6) begin lvl = !lvl; exp_lv[nb] = lvl; nb++; ones = 0; end
        if (by[k]) ones++;
        else begin lvl = !lvl; ones = 0; end
        exp_lv[nb] = lvl; nb++;
      end
    end
    if (ones == 6) begin lvl = !lvl; exp_lv[nb] = lvl; nb++; end
  endtask

  function automatic int pins();
    return {29'd0, line_oe, line_dp, line_dm};
  endfunction

  task automatic send_pkt(input int cnt, input bit busy_start);
    bit bad; int g, e;
    build(cnt);
    @(negedge clk);
    start = 1'b1; byte_count = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    chk(pins() == 3'b001, "R2 preset J with drivers off", pins(), 3'b001);
    bad = 0; g = 0; e = 0;
    for (int i = 0; i < nb; i++) begin
      for (int c = 0; c < CPB; c++) begin
        @(negedge clk);
        start = 1'b0;
        if (!bad && pins() != {1'b1, exp_lv[i], !exp_lv[i]}) begin
          bad = 1; g = pins(); e = {1'b1, exp_lv[i], !exp_lv[i]};
          $display("  bit %0d clk %0d of packet len %0d", i, c, cnt);
        end
        if (busy_start && i == 2 && c == 3) begin
          start = 1'b1; byte_count = CNT_W'(MAXB);
        end
      end
    end
    chk(!bad, "R3 R4 R5 R6 data bits", g, e);
    bad = 0; g = 0; e = 0;
    for (int c = 0; c < 3 * CPB; c++) begin
      int ev = (c < 2 * CPB) ? 3'b100 : 3'b101;
      @(negedge clk);
      if (!bad && pins() != ev) begin bad = 1; g = pins(); e = ev; end
    end
    chk(!bad, "R7 end of packet", g, e);
    @(negedge clk);
    if (cnt > 2) exp_addr = pend_addr;
    chk(pins() == 0 && done, "R7 R8 released with done", {pins(), done}, 4'b0001);
    chk(active_addr == exp_addr, "R11 address commit", active_addr, exp_addr);
    @(negedge clk);
    chk(!done, "R8 done single clock", done, 0);
    if (busy_start) begin
      bad = 0;
      for (int c = 0; c < 2 * CPB; c++) begin
        @(negedge clk);
        if (line_oe || done) bad = 1;
      end
      chk(!bad, "R9 start while busy ignored", bad, 0);
    end
  endtask

  task automatic bad_start(input int cnt);
    bit bad = 0;
    @(negedge clk);
    start = 1'b1; byte_count = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3 * CPB; c++) begin
      if (pins() != 0 || done) bad = 1;
      @(negedge clk);
    end
    chk(!bad && active_addr == exp_addr, "R10 bad length ignored", cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(pins() == 0 && !done && active_addr == 0, "R1 reset state",
        {pins(), done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pend_addr = 7'h15;
    mem[0] = 8'hD2;
    send_pkt(2, 0);
    for (int i = 0; i < 11; i++) mem[i] = 8'hFF;
    send_pkt(MAXB, 0);
    mem[0] = 8'h3F; mem[1] = 8'h7E; mem[2] = 8'hFC;
    pend_addr = 7'h2A;
    send_pkt(4, 1);
    mem[0] = 8'hFF;
    send_pkt(2, 0);
    bad_start(0);
    bad_start(1);
    bad_start(13);

    for (int n = 0; n < 40; n++) begin
      int cnt = 2 + int'($urandom_range(0, MAXB - 2));
      for (int i = 0; i < 11; i++)
        mem[i] = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
      pend_addr = 7'($urandom);
      send_pkt(cnt, (n % 7) == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule